// File: doc/BRIEF.md
# Software Trap Entry and Return Sequencer

This block carries out the memory side of a software trap in a 16-bit segmented processor. A trigger names one of four trap kinds (fixed break, numbered break, overflow break, bounds-check break) or the return from a trap. The sequencer then runs a fixed series of single-byte memory transfers. On trap entry it saves three 16-bit words on a byte-addressed stack, moves the stack pointer down by six, clears the interrupt-enable and single-step flags, and loads a new code segment and program counter from a four-byte slot in a vector table at the bottom of memory. On return it reloads the three words from the stack and moves the stack pointer up by six.

The instruction decoder presents the current status word, code segment, program counter, stack pointer and the trigger operands for one cycle together with `start`. When `done` pulses, the four result words are valid on the `*_out` ports and stay there until the next accepted trigger. The memory port is a request/acknowledge stream. The block raises `mem_req` and holds `mem_we`, `mem_space`, `mem_addr` and `mem_wdata` steady until the memory raises `mem_ack`. The byte moves on the rising edge where both are high, and read data must be valid on `mem_rdata` in that same cycle. The memory may stall for any number of cycles. The block never withdraws or changes a request that is waiting.

Top module: `trap_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and `cmd` is one of 0 (fixed break), 1 (numbered break), 2 (overflow break), 3 (bounds break) or 4 (return). `busy` rises on the next cycle. A `start` with `cmd` 5 to 7, or a `start` while `busy` is high, has no effect on the memory port or on the outputs.
- R2: On trap entry the block writes six stack-space bytes (`mem_space`=1) in this order: status high to SP−1, status low to SP−2, segment high to SP−3, segment low to SP−4, counter high to SP−5, counter low to SP−6.
- R3: After a taken trap, `sp_out` equals SP−6. After a return, it equals SP+6. All stack addresses and the result wrap modulo 2^16.
- R4: After a taken trap, `psw_out` equals the entry status word with bit 9 (interrupt enable) and bit 8 (single step) cleared and all other bits kept.
- R5: After the pushes, the block reads vector-space bytes (`mem_space`=0) at 4n, 4n+1, 4n+2 and 4n+3. These give the new counter (low, then high) and the new segment (low, then high).
- R6: The vector number n is 3 for the fixed break, `imm_vec` for the numbered break, 4 for the overflow break and 5 for the bounds break.
- R7: For the overflow break, the trap is taken only when status bit 11 is 1. Otherwise the block makes no memory access, `taken` stays 0, and all four outputs equal the entry values.
- R8: The bounds break first reads four data-space bytes (`mem_space`=2) at `bnd_addr`+0..3, giving the lower bound (low, high) and then the upper bound (low, high). It traps when, under signed 16-bit comparison, the lower bound is greater than `bnd_val` or the upper bound is less than it. Otherwise it ends with `taken`=0, no further access and unchanged outputs.
- R9: A return reads stack bytes SP+0..SP+5 as counter low/high, segment low/high, status low/high. It loads all three words unchanged, flags included, and reports `taken`=0.
- R10: While `mem_req` is high and `mem_ack` low, `mem_req`, `mem_we`, `mem_space`, `mem_addr` and `mem_wdata` keep their values on the next cycle.
- R11: `done` is high for exactly one cycle at the end of each accepted operation, with `busy` high in that cycle and low in the next. `busy` never falls before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger, sampled with the operand inputs |
| cmd | input | 3 | Operation: 0 fixed, 1 numbered, 2 overflow, 3 bounds, 4 return |
| imm_vec | input | 8 | Vector number for the numbered break |
| psw_in | input | 16 | Status word at trigger |
| cs_in | input | 16 | Code segment at trigger |
| pc_in | input | 16 | Program counter at trigger |
| sp_in | input | 16 | Stack pointer at trigger |
| bnd_addr | input | 16 | Data-space address of the bound pair |
| bnd_val | input | 16 | Register value tested against the bounds |
| mem_req | output | 1 | Byte transfer request (valid) |
| mem_ack | input | 1 | Memory accepts the transfer (ready) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_space | output | 2 | 0 vector table, 1 stack, 2 data |
| mem_addr | output | 16 | Byte address within the space |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | The finished operation entered a trap |
| psw_out | output | 16 | Resulting status word |
| cs_out | output | 16 | Resulting code segment |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
A wrong step counter or phase appears in the next transfer as a byte at the wrong address, a wrong space or a swapped high/low half, so each memory transaction is compared against the expected order as it completes. A corrupted latched word or a missed flag clear stays hidden until `done`. It then shows at once on `psw_out`, `cs_out`, `pc_out` or `sp_out`, or it shows earlier as a wrong pushed byte. A lost end-of-sequence transition shows as `done` never arriving, or as `busy` staying high in the cycle after `done`. Random memory stalls exercise the hold rule of the request on every transfer.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 3;
  localparam int STEP_W = 3;
  localparam int VEC_W  = 8;
  localparam int SPC_W  = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_BRK3  = 3'd0,
    CMD_BRKN  = 3'd1,
    CMD_BRKV  = 3'd2,
    CMD_BOUND = 3'd3,
    CMD_RET   = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_BND, PH_CHK, PH_PUSH, PH_VEC, PH_POP, PH_DONE
  } phase_e;

  localparam logic [SPC_W-1:0] SPACE_VEC = 2'd0;
  localparam logic [SPC_W-1:0] SPACE_STK = 2'd1;
  localparam logic [SPC_W-1:0] SPACE_DAT = 2'd2;
endpackage

// File: rtl/trap_addr_gen.sv
module trap_addr_gen
  import trap_seq_pkg::*;
(
  input  phase_e                  phase,
  input  logic [STEP_W-1:0]       step,
  input  logic [WORD_W-1:0]       sp,
  input  logic [VEC_W-1:0]        vec,
  input  logic [WORD_W-1:0]       bnd_base,
  input  logic [WORD_W-1:0]       psw,
  input  logic [WORD_W-1:0]       cs,
  input  logic [WORD_W-1:0]       pc,
  output logic [WORD_W-1:0]       addr,
  output logic [SPC_W-1:0]        space,
  output logic                    we,
  output logic [BYTE_W-1:0]       wdata
);
  localparam int VBASE_W = VEC_W + 2;

  logic [WORD_W-1:0] save_word;
  logic [WORD_W-1:0] step_w;
  logic [WORD_W-1:0] vec_base;

  assign step_w   = WORD_W'(step);
  assign vec_base = WORD_W'({vec, 2'b00});

  // word order on the stack: status first (highest), counter last (lowest)
  always_comb begin
    case (step[2:1])
      2'd0:    save_word = psw;
      2'd1:    save_word = cs;
      default: save_word = pc;
    endcase
  end

  always_comb begin
    addr  = '0;
    space = SPACE_STK;
    we    = 1'b0;
    wdata = '0;
    case (phase)
      PH_BND: begin
        addr  = bnd_base + step_w;
        space = SPACE_DAT;
      end
      PH_PUSH: begin
        addr  = sp - step_w - WORD_W'(1);
        we    = 1'b1;
        wdata = step[0] ? save_word[BYTE_W-1:0] : save_word[WORD_W-1:BYTE_W];
      end
      PH_VEC: begin
        addr  = vec_base + step_w;
        space = SPACE_VEC;
      end
      PH_POP: begin
        addr  = sp + step_w;
      end
      default: ;
    endcase
  end

  initial begin
    if (VBASE_W > WORD_W) $error("vector table does not fit the address");
  end
endmodule

// File: rtl/trap_bound_cmp.sv
module trap_bound_cmp
  import trap_seq_pkg::*;
(
  input  logic [WORD_W-1:0] lower,
  input  logic [WORD_W-1:0] upper,
  input  logic [WORD_W-1:0] value,
  output logic              outside
);
  logic below, above;
  assign below   = $signed(lower) > $signed(value);
  assign above   = $signed(upper) < $signed(value);
  assign outside = below || above;
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int               IE_BIT    = 9,
  parameter int               STEP_BIT  = 8,
  parameter int               OVF_BIT   = 11,
  parameter logic [VEC_W-1:0] VEC_FIXED = 8'd3,
  parameter logic [VEC_W-1:0] VEC_OVF   = 8'd4,
  parameter logic [VEC_W-1:0] VEC_BND   = 8'd5
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [VEC_W-1:0]  imm_vec,
  input  logic [WORD_W-1:0] psw_in,
  input  logic [WORD_W-1:0] cs_in,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] sp_in,
  input  logic [WORD_W-1:0] bnd_addr_in,
  input  logic [WORD_W-1:0] bnd_val_in,
  input  logic              mem_ack,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              outside,
  output phase_e            phase,
  output logic [STEP_W-1:0] step,
  output logic [WORD_W-1:0] psw_r,
  output logic [WORD_W-1:0] cs_r,
  output logic [WORD_W-1:0] pc_r,
  output logic [WORD_W-1:0] sp_r,
  output logic [WORD_W-1:0] bnd_addr_r,
  output logic [WORD_W-1:0] bnd_lo,
  output logic [WORD_W-1:0] bnd_hi,
  output logic [WORD_W-1:0] bnd_val_r,
  output logic [VEC_W-1:0]  vec_r,
  output logic              mem_req,
  output logic              busy,
  output logic              done,
  output logic              taken
);
  localparam logic [STEP_W-1:0] LAST_FOUR = STEP_W'(3);
  localparam logic [STEP_W-1:0] LAST_SIX  = STEP_W'(5);
  localparam logic [WORD_W-1:0] FRAME     = WORD_W'(6);

  cmd_e              kind_r;
  cmd_e              cmd_k;
  logic [WORD_W-1:0] sp_entry_r;
  logic              accept, xfer, last_load;

  assign cmd_k   = cmd_e'(cmd);
  assign accept  = (phase == PH_IDLE) && start && (cmd <= CMD_W'(CMD_RET));
  assign mem_req = (phase == PH_BND) || (phase == PH_PUSH) ||
                   (phase == PH_VEC) || (phase == PH_POP);
  assign xfer    = mem_req && mem_ack;
  assign busy    = (phase != PH_IDLE);
  assign done    = (phase == PH_DONE);
  assign last_load = (phase == PH_VEC) ? (step == LAST_FOUR) : (step == LAST_SIX);

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] w,
                                              input logic hi,
                                              input logic [BYTE_W-1:0] b);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      step       <= '0;
      kind_r     <= CMD_BRK3;
      psw_r      <= '0;
      cs_r       <= '0;
      pc_r       <= '0;
      sp_r       <= '0;
      sp_entry_r <= '0;
      bnd_addr_r <= '0;
      bnd_lo     <= '0;
      bnd_hi     <= '0;
      bnd_val_r  <= '0;
      vec_r      <= '0;
      taken      <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          psw_r      <= psw_in;
          cs_r       <= cs_in;
          pc_r       <= pc_in;
          sp_r       <= sp_in;
          sp_entry_r <= sp_in;
          bnd_addr_r <= bnd_addr_in;
          bnd_val_r  <= bnd_val_in;
          kind_r     <= cmd_k;
          step       <= '0;
          taken      <= 1'b0;
          case (cmd_k)
            CMD_BRK3: vec_r <= VEC_FIXED;
            CMD_BRKN: vec_r <= imm_vec;
            CMD_BRKV: vec_r <= VEC_OVF;
            default:  vec_r <= VEC_BND;
          endcase
          case (cmd_k)
            CMD_RET:   phase <= PH_POP;
            CMD_BOUND: phase <= PH_BND;
            CMD_BRKV: begin
              phase <= psw_in[OVF_BIT] ? PH_PUSH : PH_DONE;
              taken <= psw_in[OVF_BIT];
            end
            default: begin
              phase <= PH_PUSH;
              taken <= 1'b1;
            end
          endcase
        end
        PH_BND: if (xfer) begin
          if (step[1]) bnd_hi <= merge(bnd_hi, step[0], mem_rdata);
          else         bnd_lo <= merge(bnd_lo, step[0], mem_rdata);
          if (step == LAST_FOUR) begin
            step  <= '0;
            phase <= PH_CHK;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        PH_CHK: begin
          if (outside) begin
            taken <= 1'b1;
            phase <= PH_PUSH;
          end else begin
            phase <= PH_DONE;
          end
        end
        PH_PUSH: if (xfer) begin
          if (step == LAST_SIX) begin
            step            <= '0;
            sp_r            <= sp_r - FRAME;
            psw_r[IE_BIT]   <= 1'b0;
            psw_r[STEP_BIT] <= 1'b0;
            phase           <= PH_VEC;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        PH_VEC, PH_POP: if (xfer) begin
          case (step[2:1])
            2'd0:    pc_r  <= merge(pc_r,  step[0], mem_rdata);
            2'd1:    cs_r  <= merge(cs_r,  step[0], mem_rdata);
            default: psw_r <= merge(psw_r, step[0], mem_rdata);
          endcase
          if (last_load) begin
            step  <= '0;
            phase <= PH_DONE;
            if (phase == PH_POP) sp_r <= sp_r + FRAME;
          end else begin
            step <= step + STEP_W'(1);
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R11: completion is a single pulse inside the busy window
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_until_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R4: a taken trap ends with both flags low
  p_flags_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken) |-> (!psw_r[IE_BIT] && !psw_r[STEP_BIT]));
  // R3: frame size on entry and on return
  p_sp_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken) |-> (sp_r == sp_entry_r - FRAME));
  p_sp_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind_r == CMD_RET) |-> (sp_r == sp_entry_r + FRAME));
  // R7: an untaken break leaves the stack pointer alone
  p_untaken_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !taken && kind_r != CMD_RET) |-> (sp_r == sp_entry_r));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int IE_BIT   = 9,
  parameter int STEP_BIT = 8,
  parameter int OVF_BIT  = 11
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  cmd,
  input  logic [7:0]  imm_vec,
  input  logic [15:0] psw_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] bnd_addr,
  input  logic [15:0] bnd_val,
  output logic        mem_req,
  input  logic        mem_ack,
  output logic        mem_we,
  output logic [1:0]  mem_space,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic        taken,
  output logic [15:0] psw_out,
  output logic [15:0] cs_out,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out
);
  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic [WORD_W-1:0] bnd_addr_r, bnd_lo, bnd_hi, bnd_val_r;
  logic [VEC_W-1:0]  vec_r;
  logic              outside;

  trap_seq_ctrl #(
    .IE_BIT   (IE_BIT),
    .STEP_BIT (STEP_BIT),
    .OVF_BIT  (OVF_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd        (cmd),
    .imm_vec    (imm_vec),
    .psw_in     (psw_in),
    .cs_in      (cs_in),
    .pc_in      (pc_in),
    .sp_in      (sp_in),
    .bnd_addr_in(bnd_addr),
    .bnd_val_in (bnd_val),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .outside    (outside),
    .phase      (phase),
    .step       (step),
    .psw_r      (psw_out),
    .cs_r       (cs_out),
    .pc_r       (pc_out),
    .sp_r       (sp_out),
    .bnd_addr_r (bnd_addr_r),
    .bnd_lo     (bnd_lo),
    .bnd_hi     (bnd_hi),
    .bnd_val_r  (bnd_val_r),
    .vec_r      (vec_r),
    .mem_req    (mem_req),
    .busy       (busy),
    .done       (done),
    .taken      (taken)
  );

  trap_addr_gen u_addr (
    .phase    (phase),
    .step     (step),
    .sp       (sp_out),
    .vec      (vec_r),
    .bnd_base (bnd_addr_r),
    .psw      (psw_out),
    .cs       (cs_out),
    .pc       (pc_out),
    .addr     (mem_addr),
    .space    (mem_space),
    .we       (mem_we),
    .wdata    (mem_wdata)
  );

  trap_bound_cmp u_cmp (
    .lower   (bnd_lo),
    .upper   (bnd_hi),
    .value   (bnd_val_r),
    .outside (outside)
  );

  // R10: a waiting request is held unchanged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_space) && $stable(mem_wdata)));
  // R1: no memory traffic outside an accepted operation
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  // R2: stack writes only go to the stack space
  p_push_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_space == SPACE_STK));
endmodule

// File: tb/trap_seq_tb.sv
`timescale 1ns/1ps
module trap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [7:0]  imm_vec = '0;
  logic [15:0] psw_in = '0, cs_in = '0, pc_in = '0, sp_in = '0, bnd_addr = '0, bnd_val = '0;
  logic        mem_req, mem_we, busy, done, taken;
  logic        mem_ack = 1'b0;
  logic [1:0]  mem_space;
  logic [15:0] mem_addr, psw_out, cs_out, pc_out, sp_out;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int hs_bad = 0;

  logic [7:0]  vtab [0:1023];
  logic [7:0]  stk [int];
  logic [7:0]  dat [int];
  logic [26:0] lq [$];
  bit          pend = 1'b0;
  logic [26:0] pend_sig = '0;

  trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .imm_vec(imm_vec),
    .psw_in(psw_in), .cs_in(cs_in), .pc_in(pc_in), .sp_in(sp_in),
    .bnd_addr(bnd_addr), .bnd_val(bnd_val),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_space(mem_space),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .taken(taken),
    .psw_out(psw_out), .cs_out(cs_out), .pc_out(pc_out), .sp_out(sp_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] fill(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] rd(input logic [1:0] s, input logic [15:0] a);
    if (s == 2'd0) return vtab[a[9:0]];
    if (s == 2'd1) return stk.exists(int'(a)) ? stk[int'(a)] : fill(a);
    return dat.exists(int'(a)) ? dat[int'(a)] : fill(~a);
  endfunction

  // memory model: random stalls, transfer log, hold-rule watch (R10)
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (pend && ({mem_space, mem_we, mem_addr, mem_wdata} != pend_sig)) hs_bad++;
      if ($urandom_range(0, 3) != 0) begin
        mem_ack = 1'b1;
        pend = 1'b0;
        if (mem_we) begin
          if (mem_space == 2'd1) stk[int'(mem_addr)] = mem_wdata;
          lq.push_back({mem_space, 1'b1, mem_addr, mem_wdata});
        end else begin
          mem_rdata = rd(mem_space, mem_addr);
          lq.push_back({mem_space, 1'b0, mem_addr, mem_rdata});
        end
      end else begin
        pend = 1'b1;
        pend_sig = {mem_space, mem_we, mem_addr, mem_wdata};
      end
    end else begin
      pend = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic bound_trap(input logic [15:0] lo, hi, v);
    return ($signed(lo) > $signed(v)) || ($signed(hi) < $signed(v));
  endfunction

  task automatic set_bounds(input logic [15:0] a, lo, hi);
    dat[int'(a)] = lo[7:0];
    dat[int'(16'(a + 16'd1))] = lo[15:8];
    dat[int'(16'(a + 16'd2))] = hi[7:0];
    dat[int'(16'(a + 16'd3))] = hi[15:8];
  endtask

  task automatic run_op(input logic [2:0] c, input logic [7:0] iv,
                        input logic [15:0] p, cs, pc, sp, ba, bv, input bit poke);
    logic [26:0] exq [$];
    logic        tk;
    logic [7:0]  n;
    logic [7:0]  b [0:5];
    logic [15:0] ep, ecs, epc, esp, lo, hi;
    logic [15:0] words [0:2];
    int          cyc;
    bit          log_ok;
    tk = 1'b0; ep = p; ecs = cs; epc = pc; esp = sp;
    case (c)
      3'd0: n = 8'd3;
      3'd1: n = iv;
      3'd2: n = 8'd4;
      default: n = 8'd5;
    endcase
    if (c == 3'd3) begin
      for (int k = 0; k < 4; k++) begin
        b[k] = rd(2'd2, 16'(ba + 16'(k)));
        exq.push_back({2'd2, 1'b0, 16'(ba + 16'(k)), b[k]});
      end
      lo = {b[1], b[0]}; hi = {b[3], b[2]};
      tk = bound_trap(lo, hi, bv);
    end
    if (c <= 3'd1) tk = 1'b1;
    if (c == 3'd2) tk = p[11];
    if (tk) begin
      words[0] = p; words[1] = cs; words[2] = pc;
      for (int k = 0; k < 6; k++)
        exq.push_back({2'd1, 1'b1, 16'(sp - 16'(k + 1)),
                       (k % 2 == 0) ? words[k/2][15:8] : words[k/2][7:0]});
      for (int k = 0; k < 4; k++) begin
        b[k] = vtab[10'(n) * 10'd4 + 10'(k)];
        exq.push_back({2'd0, 1'b0, 16'({n, 2'b00}) + 16'(k), b[k]});
      end
      epc = {b[1], b[0]}; ecs = {b[3], b[2]};
      ep = p & ~16'h0300; esp = 16'(sp - 16'd6);
    end else if (c == 3'd4) begin
      for (int k = 0; k < 6; k++) begin
        b[k] = rd(2'd1, 16'(sp + 16'(k)));
        exq.push_back({2'd1, 1'b0, 16'(sp + 16'(k)), b[k]});
      end
      epc = {b[1], b[0]}; ecs = {b[3], b[2]}; ep = {b[5], b[4]};
      esp = 16'(sp + 16'd6);
    end
    lq.delete();
    @(negedge clk);
    start = 1'b1; cmd = c; imm_vec = iv; psw_in = p; cs_in = cs; pc_in = pc;
    sp_in = sp; bnd_addr = ba; bnd_val = bv;
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check("R1 busy after accept", 32'(busy), 32'd1);
      start = (poke && cyc == 2) ? 1'b1 : 1'b0;
      if (poke && cyc == 2) begin
        cmd = 3'd4; sp_in = 16'h1234; psw_in = 16'hFFFF;
      end
    end
    check("R11 done arrives", 32'(done), 32'd1);
    check("R11 busy with done", 32'(busy), 32'd1);
    check(c == 3'd4 ? "R9 taken" : "R7 R8 taken", 32'(taken), 32'(tk));
    check(c == 3'd4 ? "R9 psw" : "R4 psw", 32'(psw_out), 32'(ep));
    check("R5 R6 R9 cs", 32'(cs_out), 32'(ecs));
    check("R5 R6 R9 pc", 32'(pc_out), 32'(epc));
    check("R3 sp", 32'(sp_out), 32'(esp));
    log_ok = (lq.size() == exq.size());
    if (!log_ok) $display("FAIL R2 R5 R8 R9 transfer count actual=%0d expected=%0d",
                          lq.size(), exq.size());
    else for (int k = 0; k < exq.size(); k++)
      if (lq[k] !== exq[k]) begin
        if (log_ok) $display("FAIL R2 R5 R8 R9 transfer %0d actual=%h expected=%h",
                             k, lq[k], exq[k]);
        log_ok = 1'b0;
      end
    checks++;
    if (!log_ok) errors++;
    @(negedge clk);
    check("R11 done single", 32'(done), 32'd0);
    check("R11 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 1024; i++) vtab[i] = 8'($urandom_range(0, 255));
    repeat (3) @(negedge clk);
    check("R11 reset busy", 32'(busy), 32'd0);
    check("R11 reset done", 32'(done), 32'd0);
    check("R1 reset req", 32'(mem_req), 32'd0);
    check("R3 reset sp", 32'(sp_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run_op(3'd0, 8'h00, 16'hFFFF, 16'h1000, 16'h2000, 16'h0100, 16'h0, 16'h0, 1'b0); // R6 fixed
    run_op(3'd1, 8'hFF, 16'h0300, 16'hABCD, 16'h0042, 16'h0003, 16'h0, 16'h0, 1'b0); // R3 wrap, R6 top vector
    run_op(3'd2, 8'h00, 16'h0800, 16'h1111, 16'h2222, 16'h4000, 16'h0, 16'h0, 1'b0); // R7 taken
    run_op(3'd2, 8'h00, 16'hF7FF, 16'h1111, 16'h2222, 16'h4000, 16'h0, 16'h0, 1'b0); // R7 skipped
    set_bounds(16'h0200, 16'h8000, 16'h7FFF);
    run_op(3'd3, 8'h00, 16'h0200, 16'h3, 16'h4, 16'h5000, 16'h0200, 16'h0001, 1'b0); // R8 signed inside
    set_bounds(16'h0210, 16'h0000, 16'h0010);
    run_op(3'd3, 8'h00, 16'h0200, 16'h3, 16'h4, 16'h5000, 16'h0210, 16'hFFFF, 1'b0); // R8 below (signed)
    run_op(3'd3, 8'h00, 16'h0200, 16'h3, 16'h4, 16'h5000, 16'h0210, 16'h0011, 1'b0); // R8 above
    run_op(3'd3, 8'h00, 16'h0200, 16'h3, 16'h4, 16'h5000, 16'h0210, 16'h0010, 1'b0); // R8 edge inside
    run_op(3'd4, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0FFA, 16'h0, 16'h0, 1'b0);          // R9 pops frame
    run_op(3'd4, 8'h00, 16'h0, 16'h0, 16'h0, 16'hFFFC, 16'h0, 16'h0, 1'b0);          // R3 wrap on return
    run_op(3'd0, 8'h00, 16'h0200, 16'h7, 16'h8, 16'h6000, 16'h0, 16'h0, 1'b1);       // R1 start while busy

    // R1: reserved command ignored
    @(negedge clk);
    lq.delete();
    start = 1'b1; cmd = 3'd5; sp_in = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reserved cmd busy", 32'(busy), 32'd0);
    check("R1 reserved cmd traffic", 32'(lq.size()), 32'd0);
    check("R1 reserved cmd sp", 32'(sp_out), 32'h5FFA);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0]  c;
      logic [7:0]  iv;
      logic [15:0] ba;
      c  = 3'($urandom_range(0, 4));
      iv = 8'($urandom_range(0, 255));
      if (iv == 8'd3) iv = 8'd7;
      ba = 16'($urandom_range(0, 65535));
      if (c == 3'd3) set_bounds(ba, 16'($urandom_range(0, 65535)), 16'($urandom_range(0, 65535)));
      run_op(c, iv, 16'($urandom_range(0, 65535)), 16'($urandom_range(0, 65535)),
             16'($urandom_range(0, 65535)), 16'($urandom_range(0, 65535)), ba,
             16'($urandom_range(0, 65535)), 1'b0);
    end
    check("R10 request held while stalled", 32'(hs_bad), 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule